// File: doc/BRIEF.md
# Parallel ATA Device Register File

This block is the register layer on the device side of a parallel ATA target. A host talks to it through two active-low chip selects, a 3-bit register offset and single-cycle read and write strobes. The block holds the command parameters (features, sector count, sector number, cylinder, device/head). It keeps the status and error bytes and the device-control byte. It forwards the 16-bit data port to an internal FIFO. A write of the command byte starts the internal executor. The block sets BSY until the executor reports completion.

The interrupt line follows the host's access pattern. Completion sets a pending flag. A read of the primary status byte acknowledges it. A read of the alternate status byte leaves it pending. The device-control byte can mask the line or hold the device in software reset. On release from software reset, the block waits a fixed number of cycles and then restores the power-up signature values.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After rst_n, status reads 50h (DRDY bit 6, DSC bit 4), error 01h, sector count 01h, sector number 01h, cylinder low and high 00h, device/head 00h, and intrq is low.
- R2: While BSY (status bit 7) is set, a read of status or alternate status returns 0080h, with every other status bit shown as zero.
- R3: A read of status (command select, offset 7) clears the pending interrupt in the same cycle as the read.
- R4: A read of alternate status (control select, offset 6) returns the same byte as status and leaves a pending interrupt set.
- R5: A write of offset 7 with BSY clear pulses cmd_start for exactly one cycle in the following cycle, with the written byte on cmd_code. It also sets BSY.
- R6: While BSY is set, host writes to every command-select register are ignored: parameters keep their values, no command starts and the FIFO sees no write.
- R7: With the interrupt-mask bit (device control bit 1) set, intrq stays low while the interrupt remains pending. Clearing the mask drives intrq high again.
- R8: Writing device control with bit 2 set puts the device in software reset. dev_reset goes high and BSY is set from the next cycle. The parameter registers return to their R1 values and no command is accepted. Writing bit 2 clear releases the reset, and status reads 50h after RST_HOLD cycles.
- R9: Offset 0 is a 16-bit data port. A write drives fifo_wr high with fifo_wdata in the strobe cycle. A read drives fifo_rd high and returns fifo_rdata on rdata in the next cycle.
- R10: exec_done with BSY set clears BSY, loads exec_status into status bits 6..0 and exec_error into the error byte, and makes the interrupt pending.
- R11: Offset 1 is two registers: reads return the error byte, and writes go to a features byte shown on tf_feat. An access with both chip selects low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_cmd_n | input | 1 | Active-low select of the command registers (offsets 0-7) |
| cs_ctl_n | input | 1 | Active-low select of the control register (offset 6) |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | One-cycle host read strobe |
| wr_stb | input | 1 | One-cycle host write strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid the cycle after rd_stb |
| intrq | output | 1 | Interrupt request to the host |
| fifo_wr | output | 1 | Push strobe to the internal data FIFO |
| fifo_wdata | output | 16 | Word pushed to the FIFO |
| fifo_rd | output | 1 | Pop strobe to the internal data FIFO |
| fifo_rdata | input | 16 | Head word of the FIFO |
| cmd_start | output | 1 | One-cycle command start to the executor |
| cmd_code | output | 8 | Command byte |
| tf_feat | output | 8 | Features byte |
| tf_count | output | 8 | Sector count |
| tf_sector | output | 8 | Sector number |
| tf_cyl | output | 16 | Cylinder high and low |
| tf_devhead | output | 8 | Device/head byte |
| dev_reset | output | 1 | Software reset held by device control |
| exec_done | input | 1 | Executor completion pulse |
| exec_status | input | 7 | Status bits 6..0 at completion |
| exec_error | input | 8 | Error byte at completion |

## Verification
The register-access patterns cover four cases. The first is an idle read-back of each parameter. The second is a command issued and completed by a modelled executor, with the intrq level checked after each step. The third is the same flow with the interrupt masked. The fourth is a software reset entered and released. Reading alternate status and then status separates the acknowledging read from the non-acknowledging one. Writing the sector count during BSY, and writing with both selects low, tells ignored writes apart from accepted ones. Reading after the reset release shows that the signature reloads only after the hold time.

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter int RST_HOLD = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_cmd_n,
  input  logic          cs_ctl_n,
  input  logic [2:0]    addr,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          intrq,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_rd,
  input  logic [DW-1:0] fifo_rdata,
  output logic          cmd_start,
  output logic [7:0]    cmd_code,
  output logic [7:0]    tf_feat,
  output logic [7:0]    tf_count,
  output logic [7:0]    tf_sector,
  output logic [15:0]   tf_cyl,
  output logic [7:0]    tf_devhead,
  output logic          dev_reset,
  input  logic          exec_done,
  input  logic [6:0]    exec_status,
  input  logic [7:0]    exec_error
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [6:0] ST_SIG = 7'h50;

  logic          busy, nien, pend;
  logic [6:0]    st;
  logic [7:0]    err;
  logic [CW-1:0] rcnt;
  logic [7:0]    status_val;
  logic [DW-1:0] rd_mux;

  wire sel_cmd = !cs_cmd_n && cs_ctl_n;
  wire sel_ctl = cs_cmd_n && !cs_ctl_n && (addr == 3'd6);
  wire wr_cmd  = wr_stb && sel_cmd && !busy;
  wire wr_ctl  = wr_stb && sel_ctl;
  wire rd_stat = rd_stb && sel_cmd && (addr == 3'd7);
  wire done    = exec_done && busy && !dev_reset && (rcnt == '0);

  assign status_val = busy ? 8'h80 : {1'b0, st};
  assign intrq      = pend && !nien;
  assign fifo_wr    = wr_cmd && (addr == 3'd0);
  assign fifo_wdata = wdata;
  assign fifo_rd    = rd_stb && sel_cmd && (addr == 3'd0) && !busy;

  always_comb begin
    rd_mux = '0;
    if (sel_ctl) rd_mux[7:0] = status_val;
    else begin
      case (addr)
        3'd0: rd_mux = busy ? '0 : fifo_rdata;
        3'd1: rd_mux[7:0] = err;
        3'd2: rd_mux[7:0] = tf_count;
        3'd3: rd_mux[7:0] = tf_sector;
        3'd4: rd_mux[7:0] = tf_cyl[7:0];
        3'd5: rd_mux[7:0] = tf_cyl[15:8];
        3'd6: rd_mux[7:0] = tf_devhead;
        default: rd_mux[7:0] = status_val;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; nien <= 1'b0; pend <= 1'b0; dev_reset <= 1'b0;
      st <= ST_SIG; err <= 8'h01; rcnt <= '0;
      tf_feat <= 8'h00; tf_count <= 8'h01; tf_sector <= 8'h01;
      tf_cyl <= 16'h0000; tf_devhead <= 8'h00;
      cmd_start <= 1'b0; cmd_code <= 8'h00; rdata <= '0;
    end else begin
      cmd_start <= 1'b0;

      if (rcnt != '0 && !dev_reset) begin
        rcnt <= rcnt - CW'(1);
        if (rcnt == CW'(1)) begin
          busy <= 1'b0;
          st   <= ST_SIG;
        end
      end

      if (wr_cmd) begin
        case (addr)
          3'd1: tf_feat    <= wdata[7:0];
          3'd2: tf_count   <= wdata[7:0];
          3'd3: tf_sector  <= wdata[7:0];
          3'd4: tf_cyl[7:0]  <= wdata[7:0];
          3'd5: tf_cyl[15:8] <= wdata[7:0];
          3'd6: tf_devhead <= wdata[7:0];
          3'd7: begin
            busy      <= 1'b1;
            cmd_start <= 1'b1;
            cmd_code  <= wdata[7:0];
            pend      <= 1'b0;
          end
          default: ;
        endcase
      end

      if (rd_stat) pend <= 1'b0;

      if (done) begin
        busy <= 1'b0;
        st   <= exec_status;
        err  <= exec_error;
        pend <= 1'b1;
      end

      if (wr_ctl) begin
        nien <= wdata[1];
        if (wdata[2]) begin
          dev_reset <= 1'b1;
          busy      <= 1'b1;
          pend      <= 1'b0;
          rcnt      <= '0;
          err       <= 8'h01;
          tf_count  <= 8'h01;
          tf_sector <= 8'h01;
          tf_cyl    <= 16'h0000;
          tf_devhead <= 8'h00;
        end else if (dev_reset) begin
          dev_reset <= 1'b0;
          rcnt      <= CW'(RST_HOLD);
        end
      end

      if (rd_stb && (sel_cmd || sel_ctl)) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ata_taskfile_regs_chk.sv
module ata_taskfile_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_cmd_n,
  input logic        cs_ctl_n,
  input logic [2:0]  addr,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic [15:0] rdata,
  input logic        cmd_start,
  input logic [7:0]  tf_count,
  input logic        exec_done,
  input logic        busy,
  input logic        pend,
  input logic        nien
);
  wire c_sel  = !cs_cmd_n && cs_ctl_n;
  wire c_alt  = rd_stb && cs_cmd_n && !cs_ctl_n && addr == 3'd6;
  wire c_stat = rd_stb && c_sel && addr == 3'd7;

  AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    c_stat && busy |=> rdata == 16'h0080); // R2
  AST_STATUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    c_stat && !(exec_done && busy) |=> !pend); // R3
  AST_ALT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    c_alt && pend && !wr_stb |=> pend); // R4
  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R5
  AST_CMD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && c_sel && addr == 3'd7 && !busy |=> cmd_start && busy); // R5
  AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && c_sel && addr == 3'd2 && busy |=> $stable(tf_count)); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    nien && pend && !c_stat && !wr_stb |=> pend); // R7
endmodule

bind ata_taskfile_regs ata_taskfile_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n),
  .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .rdata(rdata),
  .cmd_start(cmd_start), .tf_count(tf_count), .exec_done(exec_done),
  .busy(busy), .pend(pend), .nien(nien)
);

// File: tb/ata_taskfile_regs_test.sv
module ata_taskfile_regs_test;
  localparam int HOLD = 4;

  logic clk = 0, rst_n = 0;
  logic cs_cmd_n = 1, cs_ctl_n = 1, rd_stb = 0, wr_stb = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, fifo_rdata = 16'h1234;
  logic exec_done = 0;
  logic [6:0] exec_status = 0;
  logic [7:0] exec_error = 0;
  logic [15:0] rdata, fifo_wdata, tf_cyl;
  logic intrq, fifo_wr, fifo_rd, cmd_start, dev_reset;
  logic [7:0] cmd_code, tf_feat, tf_count, tf_sector, tf_devhead;

  int total = 0, bad = 0;
  bit finished = 0, due = 0;

  typedef struct { logic [15:0] v; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  ata_taskfile_regs #(.RST_HOLD(HOLD)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic cn, input logic ln, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_cmd_n = cn; cs_ctl_n = ln; addr = a; wdata = d; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; cs_cmd_n = 1; cs_ctl_n = 1;
  endtask

  task automatic rd(input logic ctl, input logic [2:0] a, input logic [15:0] x, input string tag);
    exp_t it;
    @(negedge clk);
    cs_cmd_n = ctl; cs_ctl_n = !ctl; addr = a; rd_stb = 1;
    it.v = x; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    rd_stb = 0; cs_cmd_n = 1; cs_ctl_n = 1;
  endtask

  task automatic finish_cmd(input logic [6:0] s, input logic [7:0] er);
    @(negedge clk);
    exec_done = 1; exec_status = s; exec_error = er;
    @(negedge clk);
    exec_done = 0;
  endtask

  always @(posedge clk) due <= rd_stb;

  always @(negedge clk) if (due) begin
    if (q.size() == 0) chk(0, 1, "R9 scoreboard empty");
    else begin
      e = q.pop_front();
      chk(rdata, e.v, e.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(intrq, 0, "R1 intrq after reset");
    rd(0, 7, 16'h0050, "R1 status signature");
    rd(0, 1, 16'h0001, "R1 error signature");
    rd(0, 2, 16'h0001, "R1 sector count");
    rd(0, 3, 16'h0001, "R1 sector number");
    rd(0, 4, 16'h0000, "R1 cylinder low");
    rd(0, 5, 16'h0000, "R1 cylinder high");

    wr(0, 1, 2, 16'h0010); wr(0, 1, 3, 16'h0022); wr(0, 1, 4, 16'h0033);
    wr(0, 1, 5, 16'h0044); wr(0, 1, 6, 16'h00A0); wr(0, 1, 1, 16'h005A);
    chk(tf_feat, 8'h5A, "R11 features byte");
    chk(tf_cyl, 16'h4433, "R11 cylinder output");
    rd(0, 1, 16'h0001, "R11 offset 1 reads error");
    rd(0, 3, 16'h0022, "R11 sector number readback");
    rd(0, 6, 16'h00A0, "R11 device/head readback");
    wr(0, 0, 2, 16'h00EE);
    rd(0, 2, 16'h0010, "R11 both selects low ignored");

    @(negedge clk);
    cs_cmd_n = 0; addr = 0; wdata = 16'hBEEF; wr_stb = 1;
    #1 chk(fifo_wr, 1, "R9 fifo_wr"); chk(fifo_wdata, 16'hBEEF, "R9 fifo_wdata");
    @(negedge clk);
    wr_stb = 0; cs_cmd_n = 1;
    @(negedge clk);
    cs_cmd_n = 0; addr = 0; rd_stb = 1;
    e.v = 16'h1234; e.tag = "R9 data read"; q.push_back(e);
    #1 chk(fifo_rd, 1, "R9 fifo_rd");
    @(negedge clk);
    rd_stb = 0; cs_cmd_n = 1;

    wr(0, 1, 7, 16'h00EC);
    chk(cmd_start, 1, "R5 cmd_start pulse");
    chk(cmd_code, 8'hEC, "R5 cmd_code");
    @(negedge clk);
    chk(cmd_start, 0, "R5 single cycle");
    rd(0, 7, 16'h0080, "R2 status busy");
    rd(1, 6, 16'h0080, "R2 alt status busy");
    wr(0, 1, 2, 16'h0099);
    wr(0, 1, 7, 16'h0020);
    chk(cmd_start, 0, "R6 command while busy");
    finish_cmd(7'h58, 8'h00);
    chk(intrq, 1, "R10 interrupt on done");
    rd(1, 6, 16'h0058, "R4 alt status value");
    chk(intrq, 1, "R4 alt read keeps intrq");
    rd(0, 7, 16'h0058, "R10 status loaded");
    chk(intrq, 0, "R3 status read clears intrq");
    rd(0, 2, 16'h0010, "R6 count kept while busy");
    rd(0, 1, 16'h0000, "R10 error loaded");
    finish_cmd(7'h7F, 8'hFF);
    chk(intrq, 0, "R10 done ignored when idle");
    rd(0, 1, 16'h0000, "R10 error kept when idle");

    wr(1, 0, 6, 16'h0002);
    wr(0, 1, 7, 16'h0020);
    finish_cmd(7'h51, 8'h04);
    chk(intrq, 0, "R7 masked intrq");
    wr(1, 0, 6, 16'h0000);
    chk(intrq, 1, "R7 unmask shows pending");
    rd(0, 7, 16'h0051, "R7 status after masked cmd");
    chk(intrq, 0, "R3 ack after unmask");

    wr(0, 1, 2, 16'h0007);
    wr(1, 0, 6, 16'h0004);
    chk(dev_reset, 1, "R8 dev_reset high");
    rd(0, 7, 16'h0080, "R8 busy in reset");
    wr(0, 1, 7, 16'h0030);
    chk(cmd_start, 0, "R8 no command in reset");
    wr(1, 0, 6, 16'h0000);
    chk(dev_reset, 0, "R8 dev_reset released");
    rd(1, 6, 16'h0080, "R8 busy during hold");
    repeat (HOLD + 1) @(negedge clk);
    rd(0, 7, 16'h0050, "R8 status after release");
    rd(0, 2, 16'h0001, "R8 count signature");
    rd(0, 3, 16'h0001, "R8 sector signature");
    rd(0, 5, 16'h0000, "R8 cylinder signature");
    rd(0, 1, 16'h0001, "R8 error signature");
    chk(intrq, 0, "R8 no interrupt after reset");

    repeat (3) @(negedge clk);
    chk(q.size(), 0, "R9 scoreboard drained");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule